// File: doc/BRIEF.md
# Two-Source Subword Mix Permutation Unit

This block rearranges packed subwords between two 64-bit source operands. It picks either the even-numbered or the odd-numbered subwords of both sources and interleaves them into one 64-bit result. The subword width can be 8, 16 or 32 bits. The steering is purely combinational wiring and multiplexing, with no arithmetic. One output register stage holds the result, so a request presented with `in_valid` produces its result one clock later, flagged by `out_valid`.

The unit is a building block for permuting area-mapped two-dimensional pixel blocks, where each matrix row lives in its own register. Take four rows of a 4x4 matrix of 16-bit elements. Applying the even and odd variants at 16-bit width to row pairs, and then again at 32-bit width to the intermediate results, produces the four columns of the matrix, which is its transpose.

Subwords are numbered from 0 at the least significant end. With selected index `j = 2k + sel_odd`, result subword `2k` is subword `j` of `src_a` and result subword `2k+1` is subword `j` of `src_b`.

Top module: `subword_mix_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the unit clears `out_valid`, `result` and `out_err` to zero at that edge.
- R2: With `size` = 2'b00 (8-bit subwords), the result byte at index 2k equals byte 2k+`sel_odd` of `src_a`, and the result byte at index 2k+1 equals byte 2k+`sel_odd` of `src_b`, for k = 0..3.
- R3: With `size` = 2'b01 (16-bit subwords), the same interleaving holds on 16-bit halfwords, for k = 0..1.
- R4: With `size` = 2'b10 (32-bit subwords), `result[31:0]` is word `sel_odd` of `src_a` and `result[63:32]` is word `sel_odd` of `src_b`.
- R5: `sel_odd` = 0 takes subwords 0, 2, 4 and so on. `sel_odd` = 1 takes subwords 1, 3, 5 and so on. Index 0 is at bit 0.
- R6: `size` = 2'b11 is illegal. It yields `result` = 0 and `out_err` = 1. Every legal size yields `out_err` = 0.
- R7: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high at the clock edge, and is low otherwise.
- R8: When `in_valid` is low at a clock edge, `result` and `out_err` keep their previous values, whatever the source and control inputs are.
- R9: On four 16-bit-element matrix rows, the sequence mix-even and mix-odd at 16 bits on row pairs (0,1) and (2,3), followed by mix-even and mix-odd at 32 bits on the intermediates, yields the four matrix columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| src_a | input | 64 | First packed source; supplies even result subwords |
| src_b | input | 64 | Second packed source; supplies odd result subwords |
| size | input | 2 | Subword width: 00 = 8, 01 = 16, 10 = 32, 11 = illegal |
| sel_odd | input | 1 | 0 selects even-numbered subwords, 1 selects odd-numbered |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered permuted result |
| out_err | output | 1 | Registered flag: the request used the illegal size code |

## Verification
The assertions assume that `in_valid`, `size`, `sel_odd` and both sources are known, stable values at each rising edge. They also assume that `in_valid` is low while reset is applied, so the first post-reset cycle has a defined history. The bench changes inputs only on falling edges and lowers `in_valid` before and during every reset pulse. The illegal size code is applied only as a deliberate, separately checked request, and legal-size requests follow it to confirm that the error flag clears.

// File: rtl/mix_pkg.sv
package mix_pkg;

    localparam int WORD_W    = 64;
    localparam int NUM_SIZES = 3;
    localparam int MIN_SUB_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } sub_size_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        sub_size_e         size;
        logic              odd;
    } mix_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              err;
    } mix_res_t;

    // Subword width for granularity index g (0 -> 8, 1 -> 16, 2 -> 32).
    function automatic int sub_width(input int g);
        return MIN_SUB_W << g;
    endfunction

    function automatic logic size_is_legal(input sub_size_e s);
        return (s != SZ_BAD);
    endfunction

endpackage

// File: rtl/mix_lane_steer.sv
module mix_lane_steer #(
    parameter int WORD_W = 64,
    parameter int SUB_W  = 8
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              odd,
    output logic [WORD_W-1:0] y
);
    localparam int PAIRS = WORD_W / (2 * SUB_W);

    // Each pair slot k takes subword (2k + odd) from a into slot 2k
    // and the same subword index from b into slot 2k+1.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        localparam int LO_EVEN = (2 * k) * SUB_W;
        localparam int LO_ODD  = (2 * k + 1) * SUB_W;

        logic [SUB_W-1:0] a_pick;
        logic [SUB_W-1:0] b_pick;

        assign a_pick = odd ? a[LO_ODD +: SUB_W] : a[LO_EVEN +: SUB_W];
        assign b_pick = odd ? b[LO_ODD +: SUB_W] : b[LO_EVEN +: SUB_W];

        assign y[LO_EVEN +: SUB_W] = a_pick;
        assign y[LO_ODD  +: SUB_W] = b_pick;
    end

endmodule

// File: rtl/mix_size_mux.sv
module mix_size_mux
    import mix_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int N_CAND = 3
) (
    input  logic [N_CAND-1:0][WORD_W-1:0] cand,
    input  sub_size_e                     size,
    output logic [WORD_W-1:0]             data,
    output logic                          err
);
    always_comb begin
        data = '0;
        err  = !size_is_legal(size);
        for (int g = 0; g < N_CAND; g++) begin
            if (size == sub_size_e'(g)) begin
                data = cand[g];
            end
        end
    end

endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage
    import mix_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  mix_res_t next_res,
    output logic     valid_q,
    output mix_res_t res_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= load;
            if (load) begin
                res_q <= next_res;
            end
        end
    end

endmodule

// File: rtl/subword_mix_unit.sv
module subword_mix_unit
    import mix_pkg::*;
#(
    parameter int DATA_W = mix_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [1:0]        size,
    input  logic              sel_odd,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              out_err
);
    localparam int N_SIZES = mix_pkg::NUM_SIZES;

    mix_req_t                       req;
    logic [N_SIZES-1:0][DATA_W-1:0] cand;
    mix_res_t                       res_d;
    mix_res_t                       res_q;

    assign req.a    = src_a;
    assign req.b    = src_b;
    assign req.size = sub_size_e'(size);
    assign req.odd  = sel_odd;

    // One steering network per supported granularity.
    for (genvar g = 0; g < N_SIZES; g++) begin : g_gran
        mix_lane_steer #(
            .WORD_W (DATA_W),
            .SUB_W  (sub_width(g))
        ) u_steer (
            .a   (req.a),
            .b   (req.b),
            .odd (req.odd),
            .y   (cand[g])
        );
    end

    mix_size_mux #(
        .WORD_W (DATA_W),
        .N_CAND (N_SIZES)
    ) u_mux (
        .cand (cand),
        .size (req.size),
        .data (res_d.data),
        .err  (res_d.err)
    );

    mix_out_stage u_reg (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .next_res (res_d),
        .valid_q  (out_valid),
        .res_q    (res_q)
    );

    assign result  = res_q.data;
    assign out_err = res_q.err;

endmodule

// File: rtl/mix_unit_checker.sv
module mix_unit_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic [1:0]  size,
    input logic        sel_odd,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        out_err
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && result == 64'h0 && !out_err));

    assert_byte_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'b00 && !sel_odd) |=>
            (result[7:0] == $past(src_a[7:0]) && result[15:8] == $past(src_b[7:0])));

    assert_half_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'b01 && !sel_odd) |=>
            (result[31:16] == $past(src_b[15:0]) && result[47:32] == $past(src_a[47:32])));

    assert_word_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'b10) |=>
            (result[31:0] == ($past(sel_odd) ? $past(src_a[63:32]) : $past(src_a[31:0]))));

    assert_odd_pick_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'b01 && sel_odd) |=>
            (result[15:0] == $past(src_a[31:16]) && result[63:48] == $past(src_b[63:48])));

    assert_err_flag_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_err == ($past(size) == 2'b11)));

    assert_err_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (result == 64'h0));

    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(out_err)));

endmodule

bind subword_mix_unit mix_unit_checker u_chk (.*);

// File: tb/tb_subword_mix_unit.sv
`timescale 1ns/1ps
module tb_subword_mix_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [1:0]  size;
    logic        sel_odd;
    logic        out_valid;
    logic [63:0] result;
    logic        out_err;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    subword_mix_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .size      (size),
        .sel_odd   (sel_odd),
        .out_valid (out_valid),
        .result    (result),
        .out_err   (out_err)
    );

    // Independent model: walk destination slots, fetch the source subword.
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input int code, input bit odd);
        logic [63:0] o;
        int w;
        int n;
        o = '0;
        w = 8 << code;
        n = 64 / w;
        for (int i = 0; i < n; i++) begin
            for (int t = 0; t < w; t++) begin
                int si;
                si = (i / 2) * 2 + (odd ? 1 : 0);
                o[i * w + t] = (i % 2 == 1) ? b[si * w + t] : a[si * w + t];
            end
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one request for one cycle; sample at the next falling edge.
    task automatic issue(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] sz, input bit odd,
                         output logic [63:0] r, output logic e, output logic v);
        @(negedge clk);
        src_a    = a;
        src_b    = b;
        size     = sz;
        sel_odd  = odd;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        r = result;
        e = out_err;
        v = out_valid;
    endtask

    task automatic t_reset();
        logic [63:0] r; logic e; logic v;
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, r, e, v);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 out_valid", {63'h0, out_valid}, 64'h0);
        check("R1 result", result, 64'h0);
        check("R1 out_err", {63'h0, out_err}, 64'h0);
        rst = 1'b0;
    endtask

    task automatic t_sizes();
        logic [63:0] r; logic e; logic v;
        logic [63:0] pa [3];
        logic [63:0] pb [3];
        pa[0] = 64'h0706_0504_0302_0100; pb[0] = 64'h1716_1514_1312_1110;
        pa[1] = 64'hFEDC_BA98_7654_3210; pb[1] = 64'h0123_4567_89AB_CDEF;
        pa[2] = 64'hA5A5_0000_FFFF_5A5A; pb[2] = 64'h8000_0001_C3C3_3C3C;
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 3; c++) begin
                for (int o = 0; o < 2; o++) begin
                    issue(pa[p], pb[p], 2'(c), o[0], r, e, v);
                    if (c == 0)      check(o ? "R2 R5 byte odd"  : "R2 byte even", r, model(pa[p], pb[p], c, o[0]));
                    else if (c == 1) check(o ? "R3 R5 half odd"  : "R3 half even", r, model(pa[p], pb[p], c, o[0]));
                    else             check(o ? "R4 R5 word odd"  : "R4 word even", r, model(pa[p], pb[p], c, o[0]));
                    check("R6 legal no err", {63'h0, e}, 64'h0);
                end
            end
        end
        // Hand-worked byte-even value: a bytes 0,2,4,6 interleaved with b's.
        issue(64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 2'b00, 1'b0, r, e, v);
        check("R2 literal", r, 64'h1606_1404_1202_1000);
        issue(64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 2'b00, 1'b1, r, e, v);
        check("R5 literal", r, 64'h1707_1505_1303_1101);
    endtask

    task automatic t_illegal();
        logic [63:0] r; logic e; logic v;
        issue(64'hDEAD_BEEF_0BAD_F00D, 64'h1234_5678_9ABC_DEF0, 2'b11, 1'b0, r, e, v);
        check("R6 illegal result", r, 64'h0);
        check("R6 illegal err", {63'h0, e}, 64'h1);
        issue(64'hDEAD_BEEF_0BAD_F00D, 64'h1234_5678_9ABC_DEF0, 2'b10, 1'b0, r, e, v);
        check("R6 err clears", {63'h0, e}, 64'h0);
        check("R4 after illegal", r, 64'h9ABC_DEF0_0BAD_F00D);
    endtask

    task automatic t_timing_hold();
        logic [63:0] r; logic e; logic v; logic [63:0] keep;
        issue(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 2'b01, 1'b1, r, e, v);
        keep = r;
        check("R7 valid after one clock", {63'h0, v}, 64'h1);
        src_a   = 64'hFFFF_FFFF_FFFF_FFFF;
        src_b   = 64'h0;
        size    = 2'b11;
        sel_odd = 1'b0;
        @(negedge clk);
        check("R7 valid drops", {63'h0, out_valid}, 64'h0);
        check("R8 result held", result, keep);
        check("R8 err held", {63'h0, out_err}, 64'h0);
        @(negedge clk);
        check("R8 result still held", result, keep);
    endtask

    task automatic t_transpose();
        logic [63:0] row [4];
        logic [63:0] e01, o01, e23, o23, col, exp;
        logic e; logic v;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                row[i][j*16 +: 16] = 16'(16'hA000 + i * 16 + j);
        issue(row[0], row[1], 2'b01, 1'b0, e01, e, v);
        issue(row[0], row[1], 2'b01, 1'b1, o01, e, v);
        issue(row[2], row[3], 2'b01, 1'b0, e23, e, v);
        issue(row[2], row[3], 2'b01, 1'b1, o23, e, v);
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 4; i++) exp[i*16 +: 16] = row[i][j*16 +: 16];
            case (j)
                0: issue(e01, e23, 2'b10, 1'b0, col, e, v);
                1: issue(o01, o23, 2'b10, 1'b0, col, e, v);
                2: issue(e01, e23, 2'b10, 1'b1, col, e, v);
                default: issue(o01, o23, 2'b10, 1'b1, col, e, v);
            endcase
            check("R9 transpose column", col, exp);
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; size = 2'b00; sel_odd = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 initial result", result, 64'h0);
        check("R1 initial valid", {63'h0, out_valid}, 64'h0);
        rst = 1'b0;
        t_sizes();
        t_illegal();
        t_timing_hold();
        t_transpose();
        t_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule